// File: doc/BRIEF.md
# Dead-Zone Frame-Locked Clock Divider

This block produces a line-rate clock and an internal 8 kHz frame signal from a master clock. It keeps the frame signal aligned to an external 8 kHz reference. The logic runs on a tick clock at twice the master rate, so one tick is half a master period. A frame phase counter spans 16·DIV ticks, which is 8·DIV master periods. Bit 3 of the counter is the output clock (master/8). The frame signal is high for the first half of the frame and low for the second half. DIV is 193 for a T1-rate build and 256 for a CEPT-rate build.

Each falling edge of the reference is brought through a two-flop synchronizer. When the edge arrives, the loop reads the frame phase. A correction band of ±SIDE ticks sits around the frame signal's falling edge. SIDE is 4 ticks for DIV=193 and 512 ticks for DIV=256. A sample inside the band adjusts the phase by one tick in that frame: the counter either holds for one tick (stretch) or skips one tick (shrink). A sample outside the band changes nothing. This dead zone filters out slow wander. The `coast` input blocks all corrections, and a reference held at a constant level leaves the outputs free-running. A lock flag reports a run of frames whose samples fell outside the band.

Top module: `dzpll_core`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, the frame phase is 0. At that point `frame8k` is 1, `line_clk` is 0 and `locked` is 0.
- R2: `line_clk` has a period of 16 ticks. Counting phase p in ticks from a rising edge of `frame8k`, `line_clk` equals bit 3 of p (low for p = 0..7, high for p = 8..15).
- R3: With no reference falling edge, every frame lasts exactly 16·DIV ticks, and `frame8k` is high for 8·DIV of them (HALF = 8·DIV).
- R4: Only falling edges of `ref_in` are acted upon, and the frame is evaluated at phase p = q+2, where q is the phase at which the input first reads low. A rising edge of `ref_in` has no effect.
- R5: The correction band covers phases HALF−SIDE ≤ p < HALF+SIDE, with SIDE = 4 for DIV=193 and 512 for DIV=256. The band edges are exact.
- R6: A sample with HALF ≤ p < HALF+SIDE (frame signal low) stretches that frame by one tick, to 16·DIV+1 ticks.
- R7: A sample with HALF−SIDE ≤ p < HALF (frame signal high) shrinks that frame by one tick, to 16·DIV−1 ticks.
- R8: A sample outside the band leaves the frame at 16·DIV ticks.
- R9: While `coast` is 1, no correction is applied, wherever the sample lands.
- R10: `locked` rises after LOCK_FRAMES (4) consecutive samples outside the band. Any sample inside the band clears it, even while coasting.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the master clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Asynchronous 8 kHz reference; falling edge is the timing mark |
| coast | input | 1 | 1 inhibits all phase corrections |
| line_clk | output | 1 | Output clock, master/8 |
| frame8k | output | 1 | Internal 8 kHz frame signal, high in the first half of the frame |
| locked | output | 1 | Reference has stayed outside the correction band for LOCK_FRAMES frames |

## Verification
The bench places the reference edge at an exact tick offset within each frame, and it does so from the frame signal's own rising edge. Each band boundary is hit on both sides: HALF−SIDE−1, HALF−SIDE, HALF−1, HALF, HALF+SIDE−1 and HALF+SIDE. A wrong band limit, or a wrong choice of direction, would show up as a frame one tick too long or too short. An extra synchronizer stage would shift every boundary by one tick, and a loop that also reacted to rising edges would correct a frame it should leave alone. The lock run is checked at three and at four clean frames, and a loop that ignores `coast` would show corrected frame lengths.

// File: rtl/dzpll_pkg.sv
package dzpll_pkg;

  typedef enum logic [1:0] {
    ADJ_NONE = 2'd0,
    ADJ_SLOW = 2'd1,
    ADJ_FAST = 2'd2
  } adj_e;

  function automatic int frame_ticks(input int div);
    return 16 * div;
  endfunction

  function automatic int half_ticks(input int div);
    return 8 * div;
  endfunction

  // one side of the correction band, in ticks (half master periods)
  function automatic int band_side(input int div);
    return (div == 193) ? 4 : 512;
  endfunction

  function automatic adj_e classify(input int ph, input int div);
    int h;
    int s;
    h = half_ticks(div);
    s = band_side(div);
    if (ph >= h - s && ph < h)      return ADJ_FAST;
    else if (ph >= h && ph < h + s) return ADJ_SLOW;
    else                            return ADJ_NONE;
  endfunction

  function automatic int step(input int ph, input adj_e adj, input int div);
    int n;
    n = frame_ticks(div);
    case (adj)
      ADJ_SLOW: return ph;
      ADJ_FAST: return (ph + 2) % n;
      default:  return (ph + 1) % n;
    endcase
  endfunction

endpackage

// File: rtl/dzpll_edge_sync.sv
module dzpll_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  logic [STAGES:0] sh;

  generate
    for (genvar g = 0; g <= STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) sh[g] <= 1'b1;
        else if (g == 0) sh[g] <= din;
        else sh[g] <= sh[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  assign fall = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/dzpll_phase_ctr.sv
module dzpll_phase_ctr
  import dzpll_pkg::*;
#(
  parameter int DIV = 193,
  parameter int PW  = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  adj_e          adj,
  output logic [PW-1:0] phase
);
  always_ff @(posedge clk) begin
    if (!rst_n) phase <= '0;
    else        phase <= PW'(step(int'(phase), adj, DIV));
  end
endmodule

// File: rtl/dzpll_lock_mon.sv
module dzpll_lock_mon #(
  parameter int LOCK_FRAMES = 4,
  localparam int CW = $clog2(LOCK_FRAMES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample,
  input  logic in_band,
  output logic locked
);
  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n) run <= '0;
    else if (sample) begin
      if (in_band) run <= '0;
      else if (run != CW'(LOCK_FRAMES)) run <= run + 1'b1;
    end
  end

  assign locked = (run == CW'(LOCK_FRAMES));
endmodule

// File: rtl/dzpll_core.sv
module dzpll_core
  import dzpll_pkg::*;
#(
  parameter int DIV         = 193,
  parameter int LOCK_FRAMES = 4,
  parameter int SYNC_STAGES = 2,
  localparam int NT   = 16 * DIV,
  localparam int HALF = 8 * DIV,
  localparam int PW   = $clog2(NT)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic coast,
  output logic line_clk,
  output logic frame8k,
  output logic locked
);
  logic          ref_fall;
  logic [PW-1:0] phase;
  adj_e          band_cls;
  adj_e          adj;
  logic          in_band;
  logic          adj_slow;
  logic          adj_fast;

  dzpll_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(ref_in), .fall(ref_fall)
  );

  always_comb begin
    band_cls = classify(int'(phase), DIV);
    in_band  = (band_cls != ADJ_NONE);
    adj      = (ref_fall && !coast) ? band_cls : ADJ_NONE;
  end

  assign adj_slow = (adj == ADJ_SLOW);
  assign adj_fast = (adj == ADJ_FAST);

  dzpll_phase_ctr #(.DIV(DIV), .PW(PW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .adj(adj), .phase(phase)
  );

  dzpll_lock_mon #(.LOCK_FRAMES(LOCK_FRAMES)) u_lock (
    .clk(clk), .rst_n(rst_n), .sample(ref_fall), .in_band(in_band), .locked(locked)
  );

  assign line_clk = phase[3];
  assign frame8k  = (int'(phase) < HALF);
endmodule

// File: rtl/dzpll_core_chk.sv
module dzpll_core_chk #(
  parameter int DIV = 193,
  parameter int PW  = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          coast,
  input logic          ref_fall,
  input logic          adj_slow,
  input logic          adj_fast,
  input logic          in_band,
  input logic          locked,
  input logic [PW-1:0] phase
);
  localparam int NT   = 16 * DIV;
  localparam int HALF = 8 * DIV;
  localparam int SIDE = (DIV == 193) ? 4 : 512;

  // R6: a stretch holds the phase for one tick
  a_r6_stretch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    adj_slow |=> phase == $past(phase));

  // R7: a shrink skips one tick
  a_r7_shrink_skips: assert property (@(posedge clk) disable iff (!rst_n)
    adj_fast |=> int'(phase) == (int'($past(phase)) + 2) % NT);

  // R3: without correction the phase advances by one
  a_r3_plain_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!adj_slow && !adj_fast) |=> int'(phase) == (int'($past(phase)) + 1) % NT);

  // R5: corrections only inside the band, on the right side
  a_r5_slow_side: assert property (@(posedge clk) disable iff (!rst_n)
    adj_slow |-> (int'(phase) >= HALF && int'(phase) < HALF + SIDE));
  a_r5_fast_side: assert property (@(posedge clk) disable iff (!rst_n)
    adj_fast |-> (int'(phase) >= HALF - SIDE && int'(phase) < HALF));

  // R9: coasting suppresses corrections
  a_r9_coast: assert property (@(posedge clk) disable iff (!rst_n)
    coast |-> !(adj_slow || adj_fast));

  // R4: a correction needs a reference falling edge, one kind at a time
  a_r4_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_slow || adj_fast) |-> ref_fall);
  a_r4_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({adj_slow, adj_fast}));

  // R10: an in-band sample clears the lock flag
  a_r10_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_fall && in_band) |=> !locked);
endmodule

bind dzpll_core dzpll_core_chk #(.DIV(DIV), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .coast(coast), .ref_fall(ref_fall),
  .adj_slow(adj_slow), .adj_fast(adj_fast), .in_band(in_band),
  .locked(locked), .phase(phase)
);

// File: tb/dzpll_core_bench.sv
`timescale 1ns/1ps
module dzpll_core_bench;
  localparam int NA = 16 * 193, HA = 8 * 193, SA = 4;
  localparam int NB = 16 * 256, HB = 8 * 256, SB = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_a = 1'b1, ref_b = 1'b1, coast = 1'b0;
  logic lc_a, f8_a, lk_a, lc_b, f8_b, lk_b;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  dzpll_core #(.DIV(193)) u_dzpll_core (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_a), .coast(coast),
    .line_clk(lc_a), .frame8k(f8_a), .locked(lk_a));

  dzpll_core #(.DIV(256)) u_dzpll_core_cept (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_b), .coast(coast),
    .line_clk(lc_b), .frame8k(f8_b), .locked(lk_b));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic f8(input bit sel);
    return sel ? f8_b : f8_a;
  endfunction

  task automatic wait_rise(input bit sel);
    while (f8(sel) !== 1'b0) @(negedge clk);
    while (f8(sel) !== 1'b1) @(negedge clk);
  endtask

  // Starts at the negedge where frame8k has just risen (phase 0).
  // dly < 0: reference left high. Ends at the next rising negedge.
  task automatic frame(input bit sel, input int dly, output int len, output int highs);
    logic prev;
    prev = 1'b1;
    len = 0;
    highs = 1;
    forever begin
      if (dly >= 0 && len == dly) begin
        if (sel) ref_b = 1'b0; else ref_a = 1'b0;
      end
      if (dly >= 0 && len == dly + 40) begin
        if (sel) ref_b = 1'b1; else ref_a = 1'b1;
      end
      @(negedge clk);
      len++;
      if (f8(sel) && !prev) break;
      if (f8(sel)) highs++;
      prev = f8(sel);
    end
  endtask

  task automatic len_check(input bit sel, input int dly, input int exp, input string req);
    int len, highs;
    frame(sel, dly, len, highs);
    check(len == exp, req, len, exp);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    int len, highs, bad;
    repeat (5) @(negedge clk);
    // R1: reset state
    check(f8_a == 1'b1 && lc_a == 1'b0 && lk_a == 1'b0, "R1 reset A", {f8_a, lc_a, lk_a}, 3'b100);
    check(f8_b == 1'b1 && lc_b == 1'b0 && lk_b == 1'b0, "R1 reset B", {f8_b, lc_b, lk_b}, 3'b100);
    rst_n = 1'b1;

    // R2: line clock is phase bit 3
    wait_rise(1'b0);
    bad = 0;
    for (int i = 0; i < 48; i++) begin
      if (lc_a !== ((i >> 3) & 1)) bad++;
      if (i != 47) @(negedge clk);
    end
    check(bad == 0, "R2 line_clk A", bad, 0);

    // R3: free-running frame length and half-high duty
    wait_rise(1'b0);
    for (int k = 0; k < 2; k++) begin
      frame(1'b0, -1, len, highs);
      check(len == NA, "R3 frame len A", len, NA);
      check(highs == HA, "R3 frame8k high A", highs, HA);
    end
    check(lk_a == 1'b0, "R10 no lock without samples", lk_a, 0);

    // R6: stretch
    for (int k = 0; k < 3; k++) len_check(1'b0, HA, NA + 1, "R6 stretch");
    check(lk_a == 1'b0, "R10 unlocked while stretching", lk_a, 0);

    // R8 and R10: out-of-band samples, lock after four
    for (int k = 0; k < 4; k++) begin
      len_check(1'b0, 100, NA, "R8 out of band");
      if (k == 2) check(lk_a == 1'b0, "R10 three frames", lk_a, 0);
      if (k == 3) check(lk_a == 1'b1, "R10 four frames", lk_a, 1);
    end

    // R7: shrink, and lock drops
    len_check(1'b0, HA - 4, NA - 1, "R7 shrink");
    check(lk_a == 1'b0, "R10 unlock on correction", lk_a, 0);
    len_check(1'b0, HA - 4, NA - 1, "R7 shrink again");

    // R5: exact band edges (sample phase = delay + 2)
    len_check(1'b0, HA - 2, NA + 1, "R5 p=HALF stretch");
    len_check(1'b0, HA - 3, NA - 1, "R5 p=HALF-1 shrink");
    len_check(1'b0, HA + SA - 3, NA + 1, "R5 p=HALF+SIDE-1 stretch");
    len_check(1'b0, HA + SA - 2, NA, "R5 p=HALF+SIDE none");
    len_check(1'b0, HA - SA - 2, NA - 1, "R5 p=HALF-SIDE shrink");
    len_check(1'b0, HA - SA - 3, NA, "R5 p=HALF-SIDE-1 none");

    // R4: a rising edge inside the band does nothing
    len_check(1'b0, HA - 42, NA, "R4 rising edge ignored");

    // R9: coasting
    coast = 1'b1;
    for (int k = 0; k < 3; k++) len_check(1'b0, 100, NA, "R9 far while coasting");
    len_check(1'b0, HA, NA, "R9 coast no stretch");
    check(lk_a == 1'b0, "R10 in-band sample while coasting clears lock", lk_a, 0);
    len_check(1'b0, HA - 4, NA, "R9 coast no shrink");
    coast = 1'b0;

    // Second build, DIV=256
    wait_rise(1'b1);
    bad = 0;
    for (int i = 0; i < 32; i++) begin
      if (lc_b !== ((i >> 3) & 1)) bad++;
      if (i != 31) @(negedge clk);
    end
    check(bad == 0, "R2 line_clk B", bad, 0);
    wait_rise(1'b1);
    frame(1'b1, -1, len, highs);
    check(len == NB, "R3 frame len B", len, NB);
    check(highs == HB, "R3 frame8k high B", highs, HB);
    len_check(1'b1, HB + 500, NB + 1, "R6 stretch B");
    len_check(1'b1, HB + SB - 3, NB + 1, "R5 B p=HALF+SIDE-1");
    len_check(1'b1, HB + SB - 2, NB, "R5 B p=HALF+SIDE");
    len_check(1'b1, HB - SB - 2, NB - 1, "R7 shrink B p=HALF-SIDE");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule